// File: doc/BRIEF.md
# Supervisor Reset Generator with Watchdog

This block drives an active-low processor reset from two power flags and a watchdog input. While the main supply is reported bad, or while the power-up-valid flag is low, reset is held asserted. Once both flags are good, reset stays asserted for a fixed number of millisecond ticks and then releases.

After release, a watchdog counts millisecond ticks. Any transition on the watchdog input, rising or falling, restarts the count. If the count reaches the timeout with no transition, reset is asserted again. It then releases after the same hold delay as a power recovery.

A watchdog-enable input stands in for a floating watchdog pin. When it is low, the counter retriggers itself at seven eighths of the timeout, so no timeout can occur. All logic runs on one clock. A single-cycle `tick_1ms` strobe provides the time base. The hold delay and the timeout are parameters counted in ticks.

Top module: `supv_reset_top`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `rst_n` is 0.
- R2: When `pwr_valid` is 0, `rst_n` is 0 one clock later, even if `supply_ok` is 1. Ticks do not move the hold count toward release.
- R3: When `supply_ok` drops to 0, `rst_n` is 0 one clock later.
- R4: With both `supply_ok` and `pwr_valid` at 1, `rst_n` stays 0 through the first DELAY_TICKS-1 ticks. It becomes 1 on the clock after the DELAY_TICKS-th tick is sampled.
- R5: If either flag drops during the hold, the hold count restarts from zero. A full DELAY_TICKS ticks are then needed after the flags are good again.
- R6: A rising edge and a falling edge on `wd_in` each restart the watchdog count. An edge takes effect within three clocks, after a two-flop synchronizer.
- R7: With `wd_en` at 1, suppose TIMEOUT_TICKS ticks arrive since the last release or accepted edge, with no edge in between. Then `rst_n` is 0 on the clock after the last of those ticks. After only TIMEOUT_TICKS-1 such ticks, `rst_n` is still 1.
- R8: After a watchdog timeout, `rst_n` stays 0 for exactly DELAY_TICKS ticks and then returns to 1.
- R9: The watchdog count is held at zero while reset is asserted, however many ticks arrive. It starts from zero on release.
- R10: With `wd_en` at 0, the watchdog count wraps to zero on every (TIMEOUT_TICKS*7/8)-th tick, and no timeout occurs. When `wd_en` returns to 1, counting continues from the wrapped value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | Single-cycle time-base strobe, one per millisecond |
| supply_ok | input | 1 | Main supply above the reset threshold |
| pwr_valid | input | 1 | Some supply high enough for the reset output to be driven |
| wd_in | input | 1 | Watchdog input from the processor, asynchronous |
| wd_en | input | 1 | 1 = watchdog in use, 0 = input unused (internal retrigger) |
| rst_n | output | 1 | Active-low processor reset, registered |

## Verification
The hardest states to reach from the ports are the phase of the self-retrigger cycle and the exact timeout boundary. The watchdog count itself cannot be seen.

To reach the phase, the stimulus holds the enable low for a tick count that is not a multiple of the retrigger period. It then raises the enable and counts the ticks to the first timeout, which reveals where the hidden count wrapped.

For the boundary, the bench fixes the tick count after each release or kick. It applies exactly one tick fewer than the timeout, then one more tick. Kicks are given time to pass the synchronizer before the next tick.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [0:0] {
    HOLD_ST = 1'b0,
    RUN_ST  = 1'b1
  } hold_state_t;

  function automatic int unsigned retrig_point(input int unsigned timeout);
    return (timeout * 7) / 8;
  endfunction
endpackage

// File: rtl/supv_edge_sync.sv
module supv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic kick
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  generate
    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  // chain[STAGES] remembers the previous synchronized level
  assign kick = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer
  import supv_pkg::*;
#(
  parameter int DELAY_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold_req,
  output logic rst_n_q
);
  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  hold_state_t state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= HOLD_ST;
      cnt     <= '0;
      rst_n_q <= 1'b0;
    end else if (hold_req) begin
      state   <= HOLD_ST;
      cnt     <= '0;
      rst_n_q <= 1'b0;
    end else if (state == HOLD_ST && tick) begin
      if (cnt == LAST) begin
        state   <= RUN_ST;
        cnt     <= '0;
        rst_n_q <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    hold_req |=> !rst_n_q);

  // R4
  release_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_q) |-> $past(tick));
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
  import supv_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  input  logic kick,
  input  logic wd_en,
  output logic timeout
);
  localparam int RETRIG = retrig_point(TIMEOUT_TICKS);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT_TICKS - 1);
  localparam logic [CW-1:0] RT_LAST = CW'(RETRIG - 1);

  logic [CW-1:0] cnt;

  assign timeout = active && wd_en && tick && !kick && (cnt == TO_LAST);

  always_ff @(posedge clk) begin
    if (rst || !active || kick) begin
      cnt <= '0;
    end else if (tick) begin
      if (wd_en && cnt == TO_LAST)       cnt <= '0;
      else if (!wd_en && cnt >= RT_LAST) cnt <= '0;
      else                               cnt <= cnt + 1'b1;
    end
  end

  // R9
  wd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> cnt == '0);

  // R10
  no_timeout_off_chk: assert property (@(posedge clk) disable iff (rst)
    !wd_en |-> !timeout);
endmodule

// File: rtl/supv_reset_top.sv
module supv_reset_top #(
  parameter int DELAY_TICKS   = 100,
  parameter int TIMEOUT_TICKS = 800,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic supply_ok,
  input  logic pwr_valid,
  input  logic wd_in,
  input  logic wd_en,
  output logic rst_n
);
  logic kick;
  logic wd_timeout;
  logic hold_req;

  assign hold_req = !supply_ok || !pwr_valid || wd_timeout;

  supv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (wd_in),
    .kick (kick)
  );

  supv_hold_timer #(.DELAY_TICKS(DELAY_TICKS)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_1ms),
    .hold_req (hold_req),
    .rst_n_q  (rst_n)
  );

  supv_watchdog #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_wd (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_1ms),
    .active  (rst_n),
    .kick    (kick),
    .wd_en   (wd_en),
    .timeout (wd_timeout)
  );

  // R7
  timeout_resets_chk: assert property (@(posedge clk) disable iff (rst)
    wd_timeout |=> !rst_n);

  // R2
  pwr_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_valid |=> !rst_n);
endmodule

// File: tb/supv_reset_top_test.sv
module supv_reset_top_test;
  localparam int DLY = 4;
  localparam int TO  = 16;

  typedef struct {
    logic  val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst, tick_1ms, supply_ok, pwr_valid, wd_in, wd_en, rst_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  supv_reset_top #(.DELAY_TICKS(DLY), .TIMEOUT_TICKS(TO)) uut (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .supply_ok(supply_ok),
    .pwr_valid(pwr_valid), .wd_in(wd_in), .wd_en(wd_en), .rst_n(rst_n)
  );

  // monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rst_n !== e.val) begin
        errors++;
        $display("FAIL %s: rst_n=%b expected=%b", e.req, rst_n, e.val);
      end
    end
  end

  task automatic expect_rst(input logic v, input string req);
    exp_t e;
    e.val = v;
    e.req = req;
    #1 q.push_back(e);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1'b1;
      @(negedge clk) tick_1ms = 1'b0;
    end
  endtask

  task automatic toggle_wd();
    @(negedge clk) wd_in = ~wd_in;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick_1ms = 1'b0; supply_ok = 1'b0; pwr_valid = 1'b0;
    wd_in = 1'b0; wd_en = 1'b1;
    repeat (3) @(negedge clk);
    expect_rst(1'b0, "R1 during reset");
    rst = 1'b0;
    expect_rst(1'b0, "R1 after reset");

    supply_ok = 1'b1;
    ticks(6);
    expect_rst(1'b0, "R2 power-up flag low holds reset");
    pwr_valid = 1'b1;
    ticks(DLY - 1);
    expect_rst(1'b0, "R4 one tick short of delay");
    ticks(1);
    expect_rst(1'b1, "R4 release at delay");

    ticks(TO - 1);
    expect_rst(1'b1, "R7 one tick short of timeout");
    toggle_wd();
    ticks(TO - 1);
    expect_rst(1'b1, "R6 rising edge restarted count");
    toggle_wd();
    ticks(TO - 1);
    expect_rst(1'b1, "R6 falling edge restarted count");
    ticks(1);
    expect_rst(1'b0, "R7 timeout asserts reset");
    ticks(DLY - 1);
    expect_rst(1'b0, "R8 hold after timeout");
    ticks(1);
    expect_rst(1'b1, "R8 release after timeout hold");

    @(negedge clk) supply_ok = 1'b0;
    expect_rst(1'b0, "R3 supply drop asserts reset");
    supply_ok = 1'b1;
    ticks(2);
    supply_ok = 1'b0;
    @(negedge clk) supply_ok = 1'b1;
    ticks(DLY - 1);
    expect_rst(1'b0, "R5 hold count restarted");
    ticks(1);
    expect_rst(1'b1, "R5 release after full delay");

    pwr_valid = 1'b0;
    expect_rst(1'b0, "R2 power-up flag drop asserts reset");
    pwr_valid = 1'b1;
    supply_ok = 1'b0;
    ticks(20);
    supply_ok = 1'b1;
    ticks(DLY);
    expect_rst(1'b1, "R9 release after long hold");
    ticks(TO - 1);
    expect_rst(1'b1, "R9 count started from zero");
    ticks(1);
    expect_rst(1'b0, "R9 timeout at full count");
    ticks(DLY);
    expect_rst(1'b1, "R8 second release");

    wd_en = 1'b0;
    ticks(40);
    expect_rst(1'b1, "R10 no timeout while disabled");
    wd_en = 1'b1;
    ticks(3);
    expect_rst(1'b1, "R10 wrapped count continues");
    ticks(1);
    expect_rst(1'b0, "R10 timeout after retrigger phase");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule